// File: doc/BRIEF.md
# Bit-Select Latch with Demultiplexer Mode

This block holds an eight-bit word whose bits are written one at a time. A three-bit select value picks which bit a single data input reaches. Two active-low controls, a write strobe and a clear, choose how each clock cycle behaves: write the selected bit, hold every bit, drive a one-hot demultiplexer pattern, or clear the word. All inputs are sampled on the rising clock edge, and the output is a register, so a change becomes visible one cycle after it is sampled.

The usual use is as a bank of individually settable control flags fed from one serial data line. In the addressed-write mode the other seven bits keep their values, so firmware or a sequencer can change one flag without touching the rest. The same select decoder also acts as a one-of-eight router. With both controls low, only the selected output carries the data value and every other output is low.

Change the select value only while the block is holding. This avoids transient writes to the wrong bit when the same inputs drive a real latch.

Top module: `bit_select_latch`

## Requirements
- R1: While `rst` is high at a rising edge, `q` reads all zeros after that edge.
- R2: In write mode (`wr_n`=0, `clr_n`=1), bit `q[sel]` takes the value of `din` one cycle after the edge.
- R3: In write mode, every bit other than `q[sel]` keeps its previous value.
- R4: In hold mode (`wr_n`=1, `clr_n`=1), `q` is unchanged whatever `sel` and `din` are.
- R5: In demultiplexer mode (`wr_n`=0, `clr_n`=0), `q[sel]` becomes `din` and every other bit becomes 0.
- R6: In clear mode (`wr_n`=1, `clr_n`=0), `q` becomes all zeros whatever `sel` and `din` are.
- R7: `sel` is read as an unsigned binary number with `sel[0]` as its least significant bit. Value 0 addresses `q[0]` and value 7 addresses `q[7]`.
- R8: `rst` takes priority over every mode, including write and demultiplexer mode.
- R9: After demultiplexer mode, a following hold keeps the last demultiplexer pattern: the selected bit at its data value and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge sampling clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_n | input | 1 | Active-low write strobe |
| clr_n | input | 1 | Active-low clear control |
| sel | input | 3 | Binary bit select, bit 0 least significant |
| din | input | 1 | Serial data value |
| q | output | 8 | Registered parallel output word |

## Verification
Two functions can fall in the same cycle: the power-on reset and an active write or demultiplexer command. The bench provokes this by raising `rst` while the write strobe and clear are both low, with a select and a data value that would set a bit. It passes only if the word reads all zeros. A second overlap is a mode change in the same cycle as a select change. The bench leaves demultiplexer mode for hold with a new select and data value, and expects the old one-hot pattern to stay.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } bsl_mode_t;

  // Active-low strobe and clear combine into one of four modes.
  function automatic bsl_mode_t mode_of(input logic wr_n, input logic clr_n);
    case ({wr_n, clr_n})
      2'b01:   return MODE_WRITE;
      2'b11:   return MODE_HOLD;
      2'b00:   return MODE_DEMUX;
      default: return MODE_CLEAR;
    endcase
  endfunction

  // Next value of one stored bit.
  function automatic logic bit_next(input bsl_mode_t m, input logic hit,
                                    input logic d, input logic cur);
    case (m)
      MODE_WRITE: return hit ? d : cur;
      MODE_HOLD:  return cur;
      MODE_DEMUX: return hit & d;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bsl_mode_dec.sv
module bsl_mode_dec
  import bsl_pkg::*;
(
  input  logic      wr_n,
  input  logic      clr_n,
  output bsl_mode_t mode,
  output logic      is_write,
  output logic      is_hold,
  output logic      is_demux,
  output logic      is_clear
);
  always_comb begin
    mode     = mode_of(wr_n, clr_n);
    is_write = (mode == MODE_WRITE);
    is_hold  = (mode == MODE_HOLD);
    is_demux = (mode == MODE_DEMUX);
    is_clear = (mode == MODE_CLEAR);
  end
endmodule

// File: rtl/bsl_sel_dec.sv
module bsl_sel_dec #(
  parameter int WIDTH = 8,
  localparam int SEL_W = $clog2(WIDTH)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] hot
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_hot
    assign hot[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/bsl_bit_cell.sv
module bsl_bit_cell
  import bsl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bsl_mode_t mode,
  input  logic      hit,
  input  logic      din,
  output logic      q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= bit_next(mode, hit, din, q);
  end
endmodule

// File: rtl/bit_select_latch.sv
module bit_select_latch
  import bsl_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int SEL_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             clr_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  bsl_mode_t        mode;
  logic             is_write, is_hold, is_demux, is_clear;
  logic [WIDTH-1:0] hot;

  bsl_mode_dec u_mode (
    .wr_n(wr_n), .clr_n(clr_n), .mode(mode),
    .is_write(is_write), .is_hold(is_hold),
    .is_demux(is_demux), .is_clear(is_clear)
  );

  bsl_sel_dec #(.WIDTH(WIDTH)) u_sel (.sel(sel), .hot(hot));

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    bsl_bit_cell u_cell (
      .clk(clk), .rst(rst), .mode(mode),
      .hit(hot[i]), .din(din), .q(q[i])
    );
  end

  // Reset of the previous cycle must have left an all-zero word.
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1)
      p_reset_wins_r8: assert (q == '0) else $error("reset did not clear word");
  end

  p_write_bit_r2: assert property (@(posedge clk) disable iff (rst)
    is_write |=> q[$past(sel)] == $past(din));

  p_write_keep_r3: assert property (@(posedge clk) disable iff (rst)
    is_write |=> (q & ~$past(hot)) == ($past(q) & ~$past(hot)));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    is_hold |=> $stable(q));

  p_demux_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    is_demux |=> ($countones(q) == ($past(din) ? 1 : 0)) && q[$past(sel)] == $past(din));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    is_clear |=> q == '0);

  p_mode_single_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_write, is_hold, is_demux, is_clear}));
endmodule

// File: tb/bit_select_latch_test.sv
module bit_select_latch_test;
  localparam int CLK_P = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1;
  logic clr_n = 1'b1;
  logic [2:0] sel = '0;
  logic din = 1'b0;
  logic [7:0] q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_q = '0;

  always #(CLK_P/2) clk = ~clk;

  bit_select_latch uut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .clr_n(clr_n),
    .sel(sel), .din(din), .q(q)
  );

  // Entry: {wr_n, clr_n, sel, din, expected q}; runs from an all-zero word.
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd3, 1'b1, 8'h08},  // R2 write
    {1'b0, 1'b1, 3'd0, 1'b1, 8'h09},  // R7 sel 0 -> bit 0
    {1'b0, 1'b1, 3'd7, 1'b1, 8'h89},  // R7 sel 7 -> bit 7
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h89},  // R4 hold
    {1'b0, 1'b1, 3'd3, 1'b0, 8'h81},  // R3 clear one bit, keep others
    {1'b0, 1'b1, 3'd6, 1'b1, 8'hC1},  // R3
    {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},  // R5 demux
    {1'b1, 1'b1, 3'd6, 1'b0, 8'h04},  // R9 hold after demux
    {1'b0, 1'b1, 3'd1, 1'b1, 8'h06},  // R2
    {1'b0, 1'b0, 3'd4, 1'b0, 8'h00},  // R5 demux with zero data
    {1'b0, 1'b1, 3'd5, 1'b1, 8'h20},  // R2
    {1'b1, 1'b0, 3'd5, 1'b1, 8'h00}   // R6 clear
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Drive at the falling edge, let one rising edge load the register, sample at the next falling edge.
  task automatic step(input logic r, input logic w, input logic c,
                      input logic [2:0] s, input logic d);
    rst = r; wr_n = w; clr_n = c; sel = s; din = d;
    @(posedge clk);
    if (r) exp_q = '0;
    else case ({w, c})
      2'b01: exp_q[s] = d;
      2'b11: ;
      2'b00: exp_q = d ? (8'd1 << s) : 8'd0;
      default: exp_q = '0;
    endcase
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", q, 8'h00);
    rst = 1'b0;
    exp_q = '0;

    for (int i = 0; i < NV; i++) begin
      step(1'b0, VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      check("vector R2-table", q, VEC[i][7:0]);
    end

    // Sweep all four modes over every select value and both data values.
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 2; d++) begin
        step(1'b0, 1'b0, 1'b1, 3'(s), 1'(d));
        check("R3 write sweep", q, exp_q);
        step(1'b0, 1'b1, 1'b1, 3'(7 - s), 1'(~d));
        check("R4 hold sweep", q, exp_q);
        step(1'b0, 1'b0, 1'b0, 3'(s), 1'(d));
        check("R5 demux sweep", q, exp_q);
        step(1'b0, 1'b1, 1'b1, 3'(s ^ 5), 1'(~d));
        check("R9 hold after demux", q, exp_q);
        step(1'b0, 1'b1, 1'b0, 3'(s), 1'b1);
        check("R6 clear sweep", q, 8'h00);
      end
    end

    // R7: fill the word bit by bit; the binary position must match.
    for (int s = 0; s < 8; s++) begin
      step(1'b0, 1'b0, 1'b1, 3'(s), 1'b1);
      check("R7 binary select", q, 8'((9'd2 << s) - 9'd1));
    end

    // R8: reset in the same cycle as a write and as a demux.
    step(1'b1, 1'b0, 1'b1, 3'd3, 1'b1);
    check("R8 reset beats write", q, 8'h00);
    step(1'b0, 1'b0, 1'b1, 3'd4, 1'b1);
    check("R2 write after reset", q, 8'h10);
    step(1'b1, 1'b0, 1'b0, 3'd6, 1'b1);
    check("R8 reset beats demux", q, 8'h00);
    step(1'b0, 1'b1, 1'b1, 3'd6, 1'b1);
    check("R1 word stays clear", q, 8'h00);

    finish_run();
  end
endmodule